// File: doc/BRIEF.md
# Bus Activity Counter Bank with Interval Snapshots

The block keeps a bank of event counters running without pause on a monitored bus. Counters 0 to 7 take strobes from the bus monitor. Counters 8 to 11 take strobes from external signals. Each counter has its own qualifier, and a strobe adds one only when that qualifier passes. The qualifier can be every bus cycle, a hit inside an inclusive address window while the address is flagged valid, or an enable from the trigger sequencer. A qualifier can also switch the counter off.

An interval timer divides the clock by a prescaler and then counts prescaled ticks. At the end of each interval every counter is captured in the same clock. The capture streams into a first-word-fall-through FIFO that the host drains at its own pace. The stream holds a header word carrying the interval sequence number, then one word per counter. After the capture, each counter either restarts from zero or keeps running, depending on the selected mode. A capture that would not fit in the FIFO is dropped whole, and a sticky flag records the loss.

Top module: `perf_count_bank`

## Requirements
- R1: A snapshot occupies NCNT+1 consecutive FIFO words: a header word, then counter 0 up to counter NCNT-1. Counter index i below NB counts `ev_bus[i]`, and index NB+j counts `ev_ext[j]`.
- R2: The qualifier of counter i is `qual_cfg[2i+1:2i]`: 0 counts every strobe, 1 counts only when `addr_vld` is high and `win_lo <= bus_addr <= win_hi` (both bounds inclusive), 2 counts only when `seq_en` is high, and 3 never counts.
- R3: A counter holds at 2^CW-1 instead of wrapping.
- R4: An interval lasts (`presc_div`+1)*(`ivl_len`+1) clock cycles from reset release. The snapshot includes strobes from the last cycle of the interval. Its first word enters the FIFO on the clock edge after that cycle, and the other words follow on consecutive edges.
- R5: With `accum_mode`=0 every counter restarts from zero after each snapshot. With `accum_mode`=1 every counter keeps its running total.
- R6: The header word is the interval sequence number. It starts at 0 after reset and advances once per interval, whether or not that interval's snapshot was kept.
- R7: When an interval ends while the FIFO has fewer than NCNT+1 free words, or while a previous snapshot is still being written, the whole snapshot is discarded and `ovf_sticky` is set. `ovf_sticky` stays set until reset, and the FIFO never takes a write while full.
- R8: After reset the FIFO is empty, `fifo_level` is 0 and `ovf_sticky` is 0.
- R9: `rd_data` shows the oldest word while `fifo_empty` is low, and `rd_en` pops it. A `rd_en` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_bus | input | NB | Bus monitor event strobes |
| ev_ext | input | NE | External event strobes |
| bus_addr | input | AW | Current bus address |
| addr_vld | input | 1 | `bus_addr` is valid this cycle |
| seq_en | input | 1 | Enable from the trigger sequencer |
| qual_cfg | input | 2*(NB+NE) | Per-counter qualifier codes |
| win_lo | input | AW | Lowest address of the window |
| win_hi | input | AW | Highest address of the window |
| accum_mode | input | 1 | 1 accumulative, 0 restart after each snapshot |
| presc_div | input | PW | Prescaler divides by this value + 1 |
| ivl_len | input | IW | Prescaled ticks per interval, minus 1 |
| rd_en | input | 1 | Pop one FIFO word |
| rd_data | output | CW | Oldest FIFO word |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_level | output | $clog2(DEPTH+1) | Words held in the FIFO |
| ovf_sticky | output | 1 | A snapshot has been dropped |

## Verification
The main stimulus is a table of single-cycle patterns run against counters that have all four qualifier codes, three counters per code. The addresses sit exactly on each window bound and one step outside it, and one in-range address is marked invalid. These patterns separate a window test that is inclusive from one that is exclusive, and they show whether the valid flag gates the test. Different strobe masks on the bus side and the external side expose mistakes in the index mapping. Sequencer-gated rows separate code 2 from code 0. The same table is then run in both count modes, and the second snapshot shows the difference between clearing and keeping the totals. Further runs cover the exact edge where the first word appears, a long stream of strobes that pushes one counter past its maximum while a neighbour stays below it, and an undrained FIFO that forces a dropped snapshot and a gap in the header numbers.

// File: rtl/perf_pkg.sv
package perf_pkg;

  typedef enum logic [1:0] {
    QUAL_ALL = 2'd0,
    QUAL_WIN = 2'd1,
    QUAL_SEQ = 2'd2,
    QUAL_OFF = 2'd3
  } qual_e;

  // Decide whether a strobe is allowed to count under a qualifier code.
  function automatic logic qual_pass(qual_e mode, logic in_win, logic seq_en);
    case (mode)
      QUAL_ALL: return 1'b1;
      QUAL_WIN: return in_win;
      QUAL_SEQ: return seq_en;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/perf_interval_timer.sv
module perf_interval_timer #(
  parameter int PW = 16,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] presc_div,
  input  logic [IW-1:0] ivl_len,
  output logic          expire
);
  logic [PW-1:0] pre_q;
  logic [IW-1:0] tick_q;
  logic          tick;

  assign tick   = (pre_q >= presc_div);
  assign expire = tick && (tick_q >= ivl_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (tick) begin
      pre_q  <= '0;
      tick_q <= expire ? '0 : tick_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice
  import perf_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  qual_e         mode,
  input  logic          in_win,
  input  logic          seq_en,
  input  logic          expire,
  input  logic          latch,
  input  logic          accum,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] snap_q
);
  localparam logic [CW-1:0] CMAX = '1;

  // Saturating increment: holds at the maximum code.
  function automatic logic [CW-1:0] sat_inc(logic [CW-1:0] v, logic hit);
    if (hit && v != CMAX) return v + 1'b1;
    return v;
  endfunction

  logic          hit;
  logic [CW-1:0] nxt;

  assign hit = ev && qual_pass(mode, in_win, seq_en);
  assign nxt = sat_inc(cnt_q, hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      if (expire) cnt_q <= accum ? nxt : '0;
      else        cnt_q <= nxt;
      if (latch)  snap_q <= nxt;
    end
  end
endmodule

// File: rtl/perf_snap_fifo.sv
module perf_snap_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PTRW = $clog2(DEPTH);
  localparam int LW   = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wp, rp;
  logic            wr_ok, rd_ok;

  assign wr_ok   = wr_en && (level != LW'(DEPTH));
  assign rd_ok   = rd_en && (level != '0);
  assign empty   = (level == '0);
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      level <= level + LW'(wr_ok) - LW'(rd_ok);
    end
  end
endmodule

// File: rtl/perf_count_bank.sv
module perf_count_bank
  import perf_pkg::*;
#(
  parameter int NB    = 8,
  parameter int NE    = 4,
  parameter int CW    = 32,
  parameter int AW    = 32,
  parameter int PW    = 16,
  parameter int IW    = 32,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NB-1:0]                ev_bus,
  input  logic [NE-1:0]                ev_ext,
  input  logic [AW-1:0]                bus_addr,
  input  logic                         addr_vld,
  input  logic                         seq_en,
  input  logic [2*(NB+NE)-1:0]         qual_cfg,
  input  logic [AW-1:0]                win_lo,
  input  logic [AW-1:0]                win_hi,
  input  logic                         accum_mode,
  input  logic [PW-1:0]                presc_div,
  input  logic [IW-1:0]                ivl_len,
  input  logic                         rd_en,
  output logic [CW-1:0]                rd_data,
  output logic                         fifo_empty,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_level,
  output logic                         ovf_sticky
);
  localparam int NCNT = NB + NE;
  localparam int NW   = NCNT + 1;
  localparam int IXW  = $clog2(NW + 1);

  // Named internal events, also used by the bound checker.
  logic               expire;
  logic               snap_accept;
  logic               snap_drop;
  logic               fifo_wr;
  logic               space_ok;
  logic               in_win;
  logic [NCNT-1:0]    ev_all;
  logic [CW-1:0]      snap_arr [NCNT];
  logic [NCNT*CW-1:0] cnt_flat;
  logic [CW-1:0]      wr_data;

  logic               busy_q;
  logic [IXW-1:0]     idx_q;
  logic [CW-1:0]      seq_q;
  logic [CW-1:0]      hdr_q;

  assign ev_all      = {ev_ext, ev_bus};
  assign in_win      = addr_vld && (bus_addr >= win_lo) && (bus_addr <= win_hi);
  assign space_ok    = (DEPTH - int'(fifo_level)) >= NW;
  assign snap_accept = expire && !busy_q && space_ok;
  assign snap_drop   = expire && !snap_accept;
  assign fifo_wr     = busy_q;

  perf_interval_timer #(.PW(PW), .IW(IW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .presc_div (presc_div),
    .ivl_len   (ivl_len),
    .expire    (expire)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_ctr
    perf_ctr_slice #(.CW(CW)) u_slice (
      .clk    (clk),
      .rst    (rst),
      .ev     (ev_all[g]),
      .mode   (qual_e'(qual_cfg[2*g +: 2])),
      .in_win (in_win),
      .seq_en (seq_en),
      .expire (expire),
      .latch  (snap_accept),
      .accum  (accum_mode),
      .cnt_q  (cnt_flat[g*CW +: CW]),
      .snap_q (snap_arr[g])
    );
  end

  // Word select for the serializer: header first, then counters by index.
  always_comb begin
    wr_data = hdr_q;
    for (int i = 0; i < NCNT; i++) begin
      if (idx_q == IXW'(i + 1)) wr_data = snap_arr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      idx_q      <= '0;
      seq_q      <= '0;
      hdr_q      <= '0;
      ovf_sticky <= 1'b0;
    end else begin
      if (expire) seq_q <= seq_q + 1'b1;
      if (snap_accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        hdr_q  <= seq_q;
      end else if (busy_q) begin
        if (idx_q == IXW'(NW - 1)) busy_q <= 1'b0;
        idx_q <= idx_q + 1'b1;
      end
      if (snap_drop) ovf_sticky <= 1'b1;
    end
  end

  perf_snap_fifo #(.W(CW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fifo_wr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .empty   (fifo_empty),
    .level   (fifo_level)
  );
endmodule

// File: rtl/perf_count_bank_chk.sv
module perf_count_bank_chk #(
  parameter int CW    = 32,
  parameter int NCNT  = 12,
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       expire,
  input logic                       snap_drop,
  input logic                       fifo_wr,
  input logic                       rd_en,
  input logic                       fifo_empty,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input logic                       ovf_sticky,
  input logic                       accum_mode,
  input logic [NCNT*CW-1:0]         cnt_flat
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CMAX = '1;

  p_drop_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
    snap_drop |=> ovf_sticky);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_sticky |=> ovf_sticky);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> (fifo_level < LW'(DEPTH)));

  p_empty_read_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fifo_empty && !fifo_wr) |=> (fifo_level == '0));

  p_restart_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (expire && !accum_mode) |=> (cnt_flat == '0));

  p_saturate_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_flat[CW-1:0] == CMAX && !expire) |=> (cnt_flat[CW-1:0] == CMAX));
endmodule

bind perf_count_bank perf_count_bank_chk #(
  .CW(CW), .NCNT(NCNT), .DEPTH(DEPTH)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .expire     (expire),
  .snap_drop  (snap_drop),
  .fifo_wr    (fifo_wr),
  .rd_en      (rd_en),
  .fifo_empty (fifo_empty),
  .fifo_level (fifo_level),
  .ovf_sticky (ovf_sticky),
  .accum_mode (accum_mode),
  .cnt_flat   (cnt_flat)
);

// File: tb/perf_count_bank_bench.sv
module perf_count_bank_bench;
  localparam int NB = 8, NE = 4, NC = NB + NE;
  localparam int CW = 8, AW = 16, PW = 8, IW = 16, DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] WLO = 16'h0100, WHI = 16'h01FF;
  localparam int NROW = 12;
  // Row fields: {events[11:0], addr[15:0], addr_vld, seq_en}
  localparam logic [29:0] VEC [NROW] = '{
    {12'hFFF, 16'h0100, 1'b1, 1'b0},
    {12'hFFF, 16'h01FF, 1'b1, 1'b1},
    {12'hFFF, 16'h0200, 1'b1, 1'b1},
    {12'hFFF, 16'h00FF, 1'b1, 1'b0},
    {12'hFFF, 16'h0150, 1'b0, 1'b0},
    {12'h0F0, 16'h0180, 1'b1, 1'b1},
    {12'h00F, 16'h0000, 1'b0, 1'b1},
    {12'hF00, 16'h01AA, 1'b1, 1'b0},
    {12'h000, 16'h0150, 1'b1, 1'b1},
    {12'h555, 16'h0120, 1'b1, 1'b1},
    {12'hAAA, 16'h0300, 1'b0, 1'b0},
    {12'hFFF, 16'h0100, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [NB-1:0] ev_bus = '0;
  logic [NE-1:0] ev_ext = '0;
  logic [AW-1:0] bus_addr = '0;
  logic addr_vld = 1'b0, seq_en = 1'b0, accum_mode = 1'b0, rd_en = 1'b0;
  logic [2*NC-1:0] qual_cfg = '0;
  logic [PW-1:0] presc_div = '0;
  logic [IW-1:0] ivl_len = '0;
  logic [CW-1:0] rd_data;
  logic fifo_empty, ovf_sticky;
  logic [LW-1:0] fifo_level;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int exp_cnt [NC];

  always #2 clk = ~clk;

  perf_count_bank #(.NB(NB), .NE(NE), .CW(CW), .AW(AW), .PW(PW), .IW(IW),
                    .DEPTH(DEPTH)) u_perf_count_bank (
    .clk(clk), .rst(rst), .ev_bus(ev_bus), .ev_ext(ev_ext),
    .bus_addr(bus_addr), .addr_vld(addr_vld), .seq_en(seq_en),
    .qual_cfg(qual_cfg), .win_lo(WLO), .win_hi(WHI), .accum_mode(accum_mode),
    .presc_div(presc_div), .ivl_len(ivl_len), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
    .ovf_sticky(ovf_sticky)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Check the head word at this negedge, then pop it.
  task automatic pop(string req, int exp);
    chk({req, " word present"}, int'(fifo_empty), 0);
    chk(req, int'(rd_data), exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic restart(logic [2*NC-1:0] q, logic acc, int pd, int il);
    rst = 1'b1;
    qual_cfg = q; accum_mode = acc;
    presc_div = PW'(pd); ivl_len = IW'(il);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_snap(string req, int hdr, bit zeros);
    pop({req, " header"}, hdr);
    for (int i = 0; i < NC; i++) pop(req, zeros ? 0 : exp_cnt[i]);
  endtask

  // Runs the vector table with counter i using qualifier code i%4.
  task automatic table_run(logic acc);
    restart(24'hE4E4E4, acc, 3, 49);
    for (int i = 0; i < NC; i++) exp_cnt[i] = 0;
    for (int r = 0; r < NROW; r++) begin
      {ev_ext, ev_bus} = VEC[r][29:18];
      bus_addr = VEC[r][17:2];
      addr_vld = VEC[r][1];
      seq_en   = VEC[r][0];
      for (int i = 0; i < NC; i++) begin
        bit ok;
        case (i % 4)
          0: ok = 1'b1;
          1: ok = addr_vld && bus_addr >= WLO && bus_addr <= WHI;
          2: ok = seq_en;
          default: ok = 1'b0;
        endcase
        if (VEC[r][18+i] && ok) exp_cnt[i]++;
      end
      @(negedge clk);
    end
    {ev_ext, ev_bus} = '0; addr_vld = 1'b0; seq_en = 1'b0;
    repeat (188) @(negedge clk);
    chk("R4 empty through last interval cycle", int'(fifo_empty), 1);
    @(negedge clk);
    chk("R4 first word one edge after expiry", int'(fifo_level), 1);
    repeat (20) @(negedge clk);
    chk("R1 full snapshot length", int'(fifo_level), NC + 1);
    read_snap("R1 R2 qualified counts", 0, 1'b0);
    repeat (186) @(negedge clk);
    if (acc) read_snap("R5 accumulative keeps totals", 1, 1'b0);
    else     read_snap("R5 restart clears totals", 1, 1'b1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    restart('0, 1'b0, 3, 49);
    chk("R8 fifo empty after reset", int'(fifo_empty), 1);
    chk("R8 level zero after reset", int'(fifo_level), 0);
    chk("R8 flag clear after reset", int'(ovf_sticky), 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 read on empty ignored", int'(fifo_level), 0);
    chk("R9 still empty", int'(fifo_empty), 1);

    table_run(1'b0);
    table_run(1'b1);

    // R3: counter 0 sees 300 strobes, counter 4 sees 100.
    restart('0, 1'b0, 3, 99);
    ev_bus = 8'h11;
    repeat (100) @(negedge clk);
    ev_bus = 8'h01;
    repeat (200) @(negedge clk);
    ev_bus = '0;
    repeat (120) @(negedge clk);
    for (int i = 0; i < NC; i++) exp_cnt[i] = 0;
    exp_cnt[0] = 255;
    exp_cnt[4] = 100;
    read_snap("R3 saturation", 0, 1'b0);

    // R6/R7: short intervals, undrained FIFO forces a drop.
    restart('0, 1'b0, 0, 19);
    repeat (45) @(negedge clk);
    chk("R7 flag set on drop", int'(ovf_sticky), 1);
    chk("R7 dropped snapshot not written", int'(fifo_level), NC + 1);
    read_snap("R7 kept snapshot", 0, 1'b1);
    repeat (20) @(negedge clk);
    pop("R6 header skips dropped interval", 2);
    chk("R7 flag stays set", int'(ovf_sticky), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule